// File: doc/BRIEF.md
# GPIO Port Edge Event and Interrupt Unit

This block watches the already-synchronized input levels of a bank of GPIO ports. Each port holds a configurable number of pins, eight by default. For every pin, software chooses one edge polarity, rising or falling. When that edge occurs, the block latches a pending bit in the port's event register. Each port has its own interrupt line. That line is high whenever at least one pending event in the port has its enable bit set.

Software services an interrupt by reading the event register, then writing ones back to the bits it has handled. Writing a zero leaves a bit untouched. A force register lets a test program inject events without toggling any pin. Each port sits in its own window on a 32-bit register bus. Writes take effect at the clock edge. Reads return data combinationally from the address.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the event, enable, force and edge-select registers of every port read as 0, and every interrupt line is low.
- R2: When a pin's edge-select bit is 0 and the pin goes from 1 to 0, the matching event bit is set at the next clock edge.
- R3: When a pin's edge-select bit is 1, a 0-to-1 transition sets the event bit. The transition of the opposite polarity never sets it.
- R4: Writing the event register clears each bit written as 1 and leaves each bit written as 0 unchanged. Without such a write, a pending bit stays set.
- R5: If a new event (from a pin edge or from force) and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R6: A port's interrupt line is the OR, over its pins, of event AND enable. Event bits still latch while their enable bit is 0.
- R7: Every force bit held at 1 sets its event bit on every cycle. After the force register is written back to 0, the cleared events stay cleared.
- R8: Writing a pin's edge-select bit while the pin level is steady does not create an event.
- R9: Port p occupies the window starting at p*0x30. Within it, the event register is at +0x14, the enable register at +0x18, the force register at +0x1C and the edge-select register at +0x20. Each port has its own interrupt bit port_irq[p]. Accesses to one port leave every other port unchanged.
- R10: In each register, pin i maps to data bit i. Bits above the pin count are ignored on write and read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_level | input | NUM_PORTS*PINS_PER_PORT | Synchronized pin levels, port p at bits [p*PINS_PER_PORT +: PINS_PER_PORT] |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, zero for unmapped addresses |
| port_irq | output | NUM_PORTS | One interrupt line per port |

## Verification
The bench targets these corner cases, each paired with the failure it would expose:
- A clear that lands in the same cycle as a fresh falling edge. A design that gives priority to the clear would silently drop that event.
- A change of edge polarity while a pin is static. A design that detects edges from the configuration, rather than from the pin history, would raise a spurious event.
- The opposite edge of a pin. A design that fires on both edges would latch it.
- Events taken while their enable is off. A design that gates the latching rather than the interrupt would lose them.
- Force held across a write-one clear, and then released. A design that samples force only once would fail the first case; one that leaves force sticky would fail the second.
- Writes to the first, a middle and the last port window. A wrong stride or offset decode would corrupt a neighbouring port or leave an interrupt line dead.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

   // Register offsets inside one port window; the bus decoder depends on them.
   localparam int unsigned OFS_EVENT  = 32'h14;
   localparam int unsigned OFS_ENABLE = 32'h18;
   localparam int unsigned OFS_FORCE  = 32'h1C;
   localparam int unsigned OFS_EDGE   = 32'h20;

   // Address match flags for the four registers of one port.
   typedef struct packed {
      logic evt;
      logic en;
      logic frc;
      logic edg;
   } port_sel_t;

endpackage

// File: rtl/evt_bus_decode.sv
module evt_bus_decode
   import gpio_evt_pkg::*;
#(
   parameter int unsigned NUM_PORTS   = 7,
   parameter int unsigned PORT_STRIDE = 48,
   parameter int unsigned ADDR_W      = 12
) (
   input  logic [ADDR_W-1:0]             addr,
   output port_sel_t [NUM_PORTS-1:0]     sel
);

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam int unsigned BASE = p * PORT_STRIDE;
      localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(BASE + OFS_EVENT);
      localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(BASE + OFS_ENABLE);
      localparam logic [ADDR_W-1:0] A_FRC = ADDR_W'(BASE + OFS_FORCE);
      localparam logic [ADDR_W-1:0] A_EDG = ADDR_W'(BASE + OFS_EDGE);

      assign sel[p].evt = (addr == A_EVT);
      assign sel[p].en  = (addr == A_EN);
      assign sel[p].frc = (addr == A_FRC);
      assign sel[p].edg = (addr == A_EDG);
   end

endmodule

// File: rtl/evt_edge_detect.sv
module evt_edge_detect #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] rise_sel,
   output logic [WIDTH-1:0] hit
);

   logic [WIDTH-1:0] hist_q;

   // History follows the pin every cycle, whatever the polarity setting.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= level;
   end

   logic [WIDTH-1:0] rose;
   logic [WIDTH-1:0] fell;
   assign rose = level & ~hist_q;
   assign fell = ~level & hist_q;

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign hit[i] = rise_sel[i] ? rose[i] : fell[i];
   end

endmodule

// File: rtl/evt_port.sv
module evt_port
   import gpio_evt_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  port_sel_t        sel,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] evt,
   output logic [WIDTH-1:0] en,
   output logic [WIDTH-1:0] frc,
   output logic [WIDTH-1:0] edg,
   output logic             irq
);

   logic [WIDTH-1:0] evt_q, en_q, frc_q, edg_q;
   logic [WIDTH-1:0] hit;
   logic [WIDTH-1:0] clr;

   evt_edge_detect #(.WIDTH(WIDTH)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (level),
      .rise_sel (edg_q),
      .hit      (hit)
   );

   assign clr = (we && sel.evt) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q <= '0;
         en_q  <= '0;
         frc_q <= '0;
         edg_q <= '0;
      end else begin
         if (we && sel.en)  en_q  <= wdata;
         if (we && sel.frc) frc_q <= wdata;
         if (we && sel.edg) edg_q <= wdata;
         // New events are ORed in after the clear, so setting wins.
         evt_q <= (evt_q & ~clr) | hit | frc_q;
      end
   end

   assign evt = evt_q;
   assign en  = en_q;
   assign frc = frc_q;
   assign edg = edg_q;
   assign irq = |(evt_q & en_q);

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
   import gpio_evt_pkg::*;
#(
   parameter int unsigned NUM_PORTS     = 7,
   parameter int unsigned PINS_PER_PORT = 8,
   parameter int unsigned PORT_STRIDE   = 48,
   parameter int unsigned ADDR_W        = 12,
   parameter int unsigned DATA_W        = 32
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_PORTS*PINS_PER_PORT-1:0]  pin_level,
   input  logic [ADDR_W-1:0]                   bus_addr,
   input  logic                                bus_we,
   input  logic [DATA_W-1:0]                   bus_wdata,
   output logic [DATA_W-1:0]                   bus_rdata,
   output logic [NUM_PORTS-1:0]                port_irq
);

   localparam int unsigned W        = PINS_PER_PORT;
   localparam int unsigned NUM_PINS = NUM_PORTS * PINS_PER_PORT;

   initial begin
      assert (W >= 1 && W <= DATA_W)
         else $error("PINS_PER_PORT must lie in 1..DATA_W");
      assert (NUM_PORTS >= 1)
         else $error("NUM_PORTS must be at least 1");
      assert (PORT_STRIDE >= OFS_EDGE + 4)
         else $error("PORT_STRIDE too small for the register window");
      assert (64'(NUM_PORTS) * 64'(PORT_STRIDE) <= (64'd1 << ADDR_W))
         else $error("ADDR_W too narrow for all port windows");
   end

   port_sel_t [NUM_PORTS-1:0] sel;
   logic [NUM_PINS-1:0] evt_all, en_all, frc_all, edg_all;
   logic [DATA_W-1:0]   rd_part [NUM_PORTS];

   evt_bus_decode #(
      .NUM_PORTS   (NUM_PORTS),
      .PORT_STRIDE (PORT_STRIDE),
      .ADDR_W      (ADDR_W)
   ) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      evt_port #(.WIDTH(W)) u_port (
         .clk   (clk),
         .rst_n (rst_n),
         .level (pin_level[p*W +: W]),
         .sel   (sel[p]),
         .we    (bus_we),
         .wdata (bus_wdata[W-1:0]),
         .evt   (evt_all[p*W +: W]),
         .en    (en_all[p*W +: W]),
         .frc   (frc_all[p*W +: W]),
         .edg   (edg_all[p*W +: W]),
         .irq   (port_irq[p])
      );

      always_comb begin
         rd_part[p] = '0;
         unique case (1'b1)
            sel[p].evt: rd_part[p][W-1:0] = evt_all[p*W +: W];
            sel[p].en:  rd_part[p][W-1:0] = en_all[p*W +: W];
            sel[p].frc: rd_part[p][W-1:0] = frc_all[p*W +: W];
            sel[p].edg: rd_part[p][W-1:0] = edg_all[p*W +: W];
            default:    rd_part[p] = '0;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int p = 0; p < NUM_PORTS; p++) bus_rdata |= rd_part[p];
   end

   if (W < DATA_W) begin : g_unused_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:W];
   end

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
   parameter int unsigned NUM_PORTS     = 7,
   parameter int unsigned PINS_PER_PORT = 8
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                bus_we,
   input logic [NUM_PORTS*PINS_PER_PORT-1:0]  pin_level,
   input logic [NUM_PORTS-1:0]                port_irq,
   input logic [NUM_PORTS*PINS_PER_PORT-1:0]  evt_all,
   input logic [NUM_PORTS*PINS_PER_PORT-1:0]  en_all,
   input logic [NUM_PORTS*PINS_PER_PORT-1:0]  frc_all,
   input logic [NUM_PORTS*PINS_PER_PORT-1:0]  edg_all
);

   localparam int unsigned N = NUM_PORTS * PINS_PER_PORT;

   logic [N-1:0] prv_q;
   logic [N-1:0] want;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv_q <= '0;
      else        prv_q <= pin_level;
   end

   always_comb begin
      for (int i = 0; i < N; i++)
         want[i] = edg_all[i] ? (pin_level[i] & ~prv_q[i]) : (~pin_level[i] & prv_q[i]);
   end

   AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (want != '0) |=> ((evt_all & $past(want)) == $past(want))); // R2

   AST_FORCE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (frc_all != '0) |=> ((evt_all & $past(frc_all)) == $past(frc_all))); // R7

   AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> ((evt_all & $past(evt_all)) == $past(evt_all))); // R4

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (en_all == '0) |-> (port_irq == '0)); // R6

   AST_CONFIG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> ($stable(en_all) && $stable(frc_all) && $stable(edg_all))); // R9

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
   .NUM_PORTS     (NUM_PORTS),
   .PINS_PER_PORT (PINS_PER_PORT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .pin_level (pin_level),
   .port_irq  (port_irq),
   .evt_all   (evt_all),
   .en_all    (en_all),
   .frc_all   (frc_all),
   .edg_all   (edg_all)
);

// File: tb/gpio_edge_irq_bench.sv
module gpio_edge_irq_bench;

   localparam int NP = 7;
   localparam int PW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NP*PW-1:0] pins = '0;
   logic [11:0]     addr = '0;
   logic            we = 1'b0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic [NP-1:0]   irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gpio_edge_irq u_gpio_edge_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_level (pins),
      .bus_addr  (addr),
      .bus_we    (we),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .port_irq  (irq)
   );

   // op: 0 write, 1 set port pins (addr = port), 2 read check, 3 irq check
   localparam logic [1:0] OP_WR = 2'd0, OP_PIN = 2'd1, OP_RD = 2'd2, OP_IRQ = 2'd3;
   localparam int NV = 39;
   localparam logic [49:0] VEC [NV] = '{
      {OP_RD,  4'd1,  12'h014, 32'h0},          // R1 event reset
      {OP_RD,  4'd1,  12'h018, 32'h0},          // R1 enable reset
      {OP_IRQ, 4'd1,  12'h000, 32'h0},          // R1 irq low
      {OP_PIN, 4'd3,  12'h000, 32'hFF},         // rising on all, falling selected
      {OP_RD,  4'd3,  12'h014, 32'h0},          // R3 opposite edge ignored
      {OP_PIN, 4'd2,  12'h000, 32'hF0},         // bits 3:0 fall
      {OP_RD,  4'd2,  12'h014, 32'h0F},         // R2
      {OP_IRQ, 4'd6,  12'h000, 32'h0},          // R6 latched but not enabled
      {OP_WR,  4'd6,  12'h018, 32'h01},
      {OP_IRQ, 4'd6,  12'h000, 32'h01},         // R6
      {OP_WR,  4'd4,  12'h014, 32'h03},
      {OP_RD,  4'd4,  12'h014, 32'h0C},         // R4 partial clear
      {OP_IRQ, 4'd6,  12'h000, 32'h0},          // R6
      {OP_WR,  4'd8,  12'h020, 32'hA5},
      {OP_RD,  4'd8,  12'h014, 32'h0C},         // R8 polarity change quiet
      {OP_RD,  4'd10, 12'h020, 32'hA5},         // R10
      {OP_PIN, 4'd3,  12'h000, 32'h0F},
      {OP_RD,  4'd3,  12'h014, 32'h5D},         // R3 mixed polarities
      {OP_WR,  4'd6,  12'h018, 32'h00},
      {OP_WR,  4'd4,  12'h014, 32'hFF},
      {OP_RD,  4'd4,  12'h014, 32'h0},          // R4 full clear
      {OP_WR,  4'd7,  12'h01C, 32'h81},
      {OP_RD,  4'd10, 12'h01C, 32'h81},         // R10 force readback
      {OP_RD,  4'd7,  12'h014, 32'h81},         // R7 forced events
      {OP_WR,  4'd5,  12'h014, 32'h81},
      {OP_RD,  4'd5,  12'h014, 32'h81},         // R5 force beats clear
      {OP_WR,  4'd7,  12'h01C, 32'h00},
      {OP_RD,  4'd7,  12'h01C, 32'h0},          // R7 force off
      {OP_WR,  4'd7,  12'h014, 32'h81},
      {OP_RD,  4'd7,  12'h014, 32'h0},          // R7 stays clear
      {OP_WR,  4'd9,  12'h078, 32'h10},
      {OP_PIN, 4'd9,  12'h002, 32'h10},
      {OP_PIN, 4'd9,  12'h002, 32'h00},
      {OP_IRQ, 4'd9,  12'h000, 32'h04},         // R9 port 2 line
      {OP_RD,  4'd9,  12'h074, 32'h10},         // R9 port 2 event
      {OP_RD,  4'd9,  12'h014, 32'h0},          // R9 port 0 untouched
      {OP_WR,  4'd4,  12'h074, 32'h10},
      {OP_IRQ, 4'd4,  12'h000, 32'h0},          // R4
      {OP_WR,  4'd10, 12'h018, 32'hFFFFFF02}
   };

   task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp,
                        input string what);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input int req, input logic [11:0] a, input logic [31:0] exp);
      addr = a;
      #1;
      check(req, rdata, exp, "read");
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         logic [1:0]  op;
         logic [3:0]  req;
         logic [11:0] a;
         logic [31:0] d;
         {op, req, a, d} = VEC[i];
         @(negedge clk);
         we = 1'b0;
         case (op)
            OP_WR:  begin addr = a; wdata = d; we = 1'b1; end
            OP_PIN: pins[a*PW +: PW] = d[7:0];
            OP_RD:  rd(int'(req), a, d);
            default: begin #1; check(int'(req), 32'(irq), d, "irq"); end
         endcase
      end
      @(negedge clk);
      we = 1'b0;
      rd(10, 12'h018, 32'h02);                  // R10 upper bits dropped

      // R5: falling edge and clear in the same cycle on port 1
      @(negedge clk); pins[PW +: PW] = 8'h01;
      @(negedge clk); pins[PW +: PW] = 8'h00;
      addr = 12'h044; wdata = 32'h01; we = 1'b1;
      @(negedge clk); we = 1'b0;
      rd(5, 12'h044, 32'h01);                   // R5 set wins
      wr(12'h044, 32'h01);
      rd(4, 12'h044, 32'h0);                    // R4

      // R9: last port window and line
      wr(12'h138, 32'h01);
      wr(12'h13C, 32'h01);
      @(negedge clk);
      #1 check(9, 32'(irq), 32'h40, "irq last port");  // R9
      rd(9, 12'h134, 32'h01);                   // R9

      // R1: reset in the middle of activity
      wr(12'h018, 32'hFF);
      wr(12'h01C, 32'h01);
      @(negedge clk);
      #1 check(1, 32'(irq), 32'h41, "irq before reset");
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1 check(1, 32'(irq), 32'h0, "irq after reset");  // R1
      rd(1, 12'h014, 32'h0);
      rd(1, 12'h01C, 32'h0);
      rd(1, 12'h13C, 32'h0);
      rd(1, 12'h020, 32'h0);
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         summary();
      end
   end

endmodule